// File: doc/BRIEF.md
# Load-Use Stall Controller

This block stalls a short in-order pipeline for one cycle when an instruction in the decode stage reads a register that a load in the execute stage has not yet returned. It contains a compact pipeline model with a fetch counter, a fetch/decode register and a decode/execute register. The stall decision can therefore be observed on the pins, together with its effect on the instruction flow over several cycles.

Each instruction word is `{kind[2:0], rs, rt, rd}`, with each register field `RAW` bits wide. When the decode/execute entry is a load and its `rt` is a non-zero register equal to the decoding instruction's `rs` or `rt`, three things happen. The fetch counter and the fetch/decode register keep their values, and the control bits written into decode/execute are cleared, which inserts a no-op. On the next cycle the held instruction moves on normally. Forwarding from the memory stage then supplies the loaded value, and that path lies outside this block.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `pc` is 0, `ex_pc` is 0, all four execute-stage control outputs are 0, and `pc_write` is 1.
- R2: The block asserts a stall when the execute-stage entry has its memory-read control set and its `rt` equals the decode instruction's `rs` or `rt`. During a stall `pc_write` and `ifid_write` are 0 and `idex_bubble` is 1, all in the same cycle.
- R3: A load whose `rt` is register 0 never causes a stall.
- R4: Only loads (kind 2) can stall. An ALU op (kind 1), a store (kind 3) or a branch (kind 4) with matching register fields does not.
- R5: During a stall `pc` and `id_pc` keep their values on the next clock edge.
- R6: The edge after a stall writes zero control bits into the execute stage, and this happens for exactly one cycle. The edge after that places the held instruction in the execute stage with its own controls.
- R7: Without a stall, `pc` advances by 1 on every clock edge.
- R8: A load followed by an unrelated instruction and then by a reader of the load's `rt` causes no stall.
- R9: Two back-to-back loads, where the second reads the first's `rt` and is followed by a reader of the second's `rt`, stall once for each dependence.
- R10: Decode maps the kinds to controls as follows. Kind 0 (no-op) sets nothing. Kind 1 sets register write. Kind 2 sets register write and memory read. Kind 3 sets memory write. Kind 4 sets branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 3+3*RAW (18) | Instruction word at address `pc` |
| pc | output | PCW (8) | Fetch counter |
| pc_write | output | 1 | Fetch counter advances on the next edge |
| ifid_write | output | 1 | Fetch/decode register loads on the next edge |
| idex_bubble | output | 1 | Decode/execute gets zeroed controls on the next edge |
| id_pc | output | PCW (8) | Address of the instruction in decode |
| ex_pc | output | PCW (8) | Address of the instruction in execute |
| ex_regwrite | output | 1 | Execute-stage register-write control |
| ex_memread | output | 1 | Execute-stage memory-read control |
| ex_memwrite | output | 1 | Execute-stage memory-write control |
| ex_branch | output | 1 | Execute-stage branch control |
| ex_rt | output | RAW (5) | Execute-stage `rt` field |
| ex_rd | output | RAW (5) | Execute-stage `rd` field |

## Verification
The main sweep places a load ahead of an ALU reader and tries every combination of load `rt`, reader `rs` and reader `rt` over registers 0 to 3. This separates true matches on either source field from mismatches and from the register-0 exemption. Producers of every other kind with matching fields show that the memory-read control alone gates the stall. Further sequences cover a load, an unrelated instruction and a reader, and a chain of dependent loads. These tell one-bubble spacing apart from a missing stall or a repeated one, through the fetch counter and the execute-stage address.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [2:0] {
    K_NOP    = 3'd0,
    K_ALU    = 3'd1,
    K_LOAD   = 3'd2,
    K_STORE  = 3'd3,
    K_BRANCH = 3'd4
  } kind_e;

  typedef struct packed {
    logic regwrite;
    logic memread;
    logic memwrite;
    logic branch;
  } ctrl_t;
endpackage

// File: rtl/ldu_decode.sv
module ldu_decode
  import ldu_pkg::*;
#(
  parameter int RAW = 5,
  localparam int IW = 3 + 3 * RAW
) (
  input  logic [IW-1:0]  instr,
  output ctrl_t          ctrl,
  output logic [RAW-1:0] rs,
  output logic [RAW-1:0] rt,
  output logic [RAW-1:0] rd
);
  logic [2:0] kind_bits;

  assign kind_bits = instr[IW-1 -: 3];
  assign rs = instr[3*RAW-1 -: RAW];
  assign rt = instr[2*RAW-1 -: RAW];
  assign rd = instr[RAW-1:0];

  always_comb begin
    ctrl = '0;
    case (kind_bits)
      K_ALU:    ctrl.regwrite = 1'b1;
      K_LOAD:   begin ctrl.regwrite = 1'b1; ctrl.memread = 1'b1; end
      K_STORE:  ctrl.memwrite = 1'b1;
      K_BRANCH: ctrl.branch = 1'b1;
      default:  ctrl = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(instr))
      p_decode_onehot_r10: assert ($countones({ctrl.memread, ctrl.memwrite, ctrl.branch}) <= 1);
  end
endmodule

// File: rtl/ldu_hazard_unit.sv
module ldu_hazard_unit #(
  parameter int RAW = 5
) (
  input  logic           ex_memread,
  input  logic [RAW-1:0] ex_rt,
  input  logic [RAW-1:0] id_rs,
  input  logic [RAW-1:0] id_rt,
  output logic           stall
);
  logic rs_hit, rt_hit, dest_live;

  assign dest_live = (ex_rt != '0);
  assign rs_hit    = (ex_rt == id_rs);
  assign rt_hit    = (ex_rt == id_rt);
  assign stall     = ex_memread && dest_live && (rs_hit || rt_hit);
endmodule

// File: rtl/ldu_pc_unit.sv
module ldu_pc_unit #(
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  output logic [PCW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else if (!hold) pc <= pc + PCW'(1);
  end

  p_advance_r7: assert property (@(posedge clk) disable iff (rst)
    !hold |=> pc == $past(pc) + PCW'(1));
  p_pc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> pc == $past(pc));
endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl
  import ldu_pkg::*;
#(
  parameter int PCW = 8,
  parameter int RAW = 5,
  localparam int IW = 3 + 3 * RAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  fetch_instr,
  output logic [PCW-1:0] pc,
  output logic           pc_write,
  output logic           ifid_write,
  output logic           idex_bubble,
  output logic [PCW-1:0] id_pc,
  output logic [PCW-1:0] ex_pc,
  output logic           ex_regwrite,
  output logic           ex_memread,
  output logic           ex_memwrite,
  output logic           ex_branch,
  output logic [RAW-1:0] ex_rt,
  output logic [RAW-1:0] ex_rd
);
  logic [IW-1:0]  ifid_instr_q;
  logic [PCW-1:0] ifid_pc_q;
  ctrl_t          ex_ctrl_q;
  logic [RAW-1:0] ex_rt_q, ex_rd_q;
  logic [PCW-1:0] ex_pc_q;

  ctrl_t          dec_ctrl;
  logic [RAW-1:0] id_rs, id_rt, id_rd;
  logic           stall;

  ldu_decode #(.RAW(RAW)) u_dec (
    .instr(ifid_instr_q), .ctrl(dec_ctrl), .rs(id_rs), .rt(id_rt), .rd(id_rd)
  );

  ldu_hazard_unit #(.RAW(RAW)) u_haz (
    .ex_memread(ex_ctrl_q.memread), .ex_rt(ex_rt_q),
    .id_rs(id_rs), .id_rt(id_rt), .stall(stall)
  );

  ldu_pc_unit #(.PCW(PCW)) u_pc (
    .clk(clk), .rst(rst), .hold(stall), .pc(pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_instr_q <= '0;
      ifid_pc_q    <= '0;
    end else if (!stall) begin
      ifid_instr_q <= fetch_instr;
      ifid_pc_q    <= pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctrl_q <= '0;
      ex_rt_q   <= '0;
      ex_rd_q   <= '0;
      ex_pc_q   <= '0;
    end else begin
      ex_ctrl_q <= stall ? ctrl_t'('0) : dec_ctrl;
      ex_rt_q   <= id_rt;
      ex_rd_q   <= id_rd;
      ex_pc_q   <= ifid_pc_q;
    end
  end

  assign pc_write    = !stall;
  assign ifid_write  = !stall;
  assign idex_bubble = stall;
  assign id_pc       = ifid_pc_q;
  assign ex_pc       = ex_pc_q;
  assign ex_regwrite = ex_ctrl_q.regwrite;
  assign ex_memread  = ex_ctrl_q.memread;
  assign ex_memwrite = ex_ctrl_q.memwrite;
  assign ex_branch   = ex_ctrl_q.branch;
  assign ex_rt       = ex_rt_q;
  assign ex_rd       = ex_rd_q;

  p_only_load_r4: assert property (@(posedge clk) disable iff (rst)
    !ex_memread |-> pc_write);
  p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_rt == '0) |-> pc_write);
  p_ifid_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ifid_write |=> $stable(id_pc));
  p_single_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |=> !idex_bubble);
  p_bubble_zero_r6: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |=> !ex_regwrite && !ex_memread && !ex_memwrite && !ex_branch);
  p_stall_pins_r2: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |-> ex_memread && !pc_write && !ifid_write);
endmodule

// File: tb/sim_ldu_stall_ctrl.sv
module sim_ldu_stall_ctrl;
  localparam int PCW = 8;
  localparam int RAW = 5;
  localparam int IW  = 3 + 3 * RAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0]  fetch_instr;
  logic [PCW-1:0] pc, id_pc, ex_pc;
  logic pc_write, ifid_write, idex_bubble;
  logic ex_regwrite, ex_memread, ex_memwrite, ex_branch;
  logic [RAW-1:0] ex_rt, ex_rd;

  logic [IW-1:0] prog [0:15];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign fetch_instr = prog[pc[3:0]];

  ldu_stall_ctrl #(.PCW(PCW), .RAW(RAW)) u0 (
    .clk(clk), .rst(rst), .fetch_instr(fetch_instr), .pc(pc),
    .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble),
    .id_pc(id_pc), .ex_pc(ex_pc), .ex_regwrite(ex_regwrite),
    .ex_memread(ex_memread), .ex_memwrite(ex_memwrite), .ex_branch(ex_branch),
    .ex_rt(ex_rt), .ex_rd(ex_rd)
  );

  function automatic logic [IW-1:0] mk(int k, int s, int t, int d);
    return {3'(k), RAW'(s), RAW'(t), RAW'(d)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic count_stalls(int edges, output int cnt);
    cnt = 0;
    for (int i = 0; i < edges; i++) begin
      step();
      if (!pc_write) cnt++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    bit exp;
    @(negedge clk);

    // R1: reset state
    clear_prog();
    do_reset();
    chk(pc == 0, "R1 pc", pc, 0);
    chk(ex_pc == 0, "R1 ex_pc", ex_pc, 0);
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b0, "R1 ctrl",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 0);
    chk(pc_write == 1'b1, "R1 pc_write", pc_write, 1);

    // R10: decode of each kind, no dependences
    clear_prog();
    prog[0] = mk(1, 1, 2, 3);
    prog[1] = mk(2, 4, 7, 0);
    prog[2] = mk(3, 5, 6, 0);
    prog[3] = mk(4, 8, 9, 0);
    do_reset();
    step(); step();
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b1000, "R10 alu",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 8);
    step();
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b1100, "R10 load",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 12);
    step();
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b0010, "R10 store",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 2);
    step();
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b0001, "R10 branch",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 1);
    step();
    chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b0000, "R10 nop",
        {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 0);

    // R2/R3/R5/R6/R7: sweep load rt against reader rs/rt
    for (int lr = 0; lr < 4; lr++) begin
      for (int cs = 0; cs < 4; cs++) begin
        for (int ct = 0; ct < 4; ct++) begin
          clear_prog();
          prog[0] = mk(2, 9, lr, 0);
          prog[1] = mk(1, cs, ct, 12);
          prog[2] = mk(1, 13, 14, 15);
          exp = (lr != 0) && (lr == cs || lr == ct);
          do_reset();
          step(); step();
          if (lr == 0)
            chk(pc_write == 1'b1 && idex_bubble == 1'b0, "R3 zero-reg load",
                idex_bubble, 0);
          else
            chk(idex_bubble == exp && pc_write == !exp && ifid_write == !exp,
                "R2 stall detect", idex_bubble, exp);
          step();
          if (exp) begin
            chk(pc == 2 && id_pc == 1, "R5 hold pc/ifid", pc, 2);
            chk({ex_regwrite, ex_memread, ex_memwrite, ex_branch} == 4'b0,
                "R6 bubble ctrl", {ex_regwrite, ex_memread, ex_memwrite, ex_branch}, 0);
            step();
            chk(ex_pc == 1 && ex_regwrite == 1'b1 && ex_rd == 12, "R6 reissue",
                ex_pc, 1);
            chk(pc == 3, "R6 single stall pc", pc, 3);
          end else begin
            chk(pc == 3, "R7 advance", pc, 3);
            chk(ex_pc == 1 && ex_regwrite == 1'b1, "R7 reader in ex", ex_pc, 1);
          end
        end
      end
    end

    // R4: non-load producers with matching rt
    for (int k = 1; k < 5; k++) begin
      if (k == 2) continue;
      clear_prog();
      prog[0] = mk(k, 9, 3, 3);
      prog[1] = mk(1, 3, 3, 12);
      do_reset();
      count_stalls(6, cnt);
      chk(cnt == 0, "R4 non-load no stall", cnt, 0);
      chk(pc == 6, "R4 pc", pc, 6);
    end

    // R8: load, unrelated, reader
    clear_prog();
    prog[0] = mk(2, 9, 4, 0);
    prog[1] = mk(1, 5, 6, 7);
    prog[2] = mk(1, 4, 4, 8);
    do_reset();
    count_stalls(8, cnt);
    chk(cnt == 0, "R8 gap no stall", cnt, 0);
    chk(pc == 8, "R8 pc", pc, 8);

    // R9: chained loads then reader
    clear_prog();
    prog[0] = mk(2, 1, 2, 0);
    prog[1] = mk(2, 2, 3, 0);
    prog[2] = mk(1, 3, 0, 5);
    do_reset();
    count_stalls(8, cnt);
    chk(cnt == 2, "R9 chained stalls", cnt, 2);
    chk(pc == 6, "R9 pc", pc, 6);

    finish_run();
  end
endmodule